// File: doc/BRIEF.md
# Local Clock and Frame Sync Generator

This block produces two independent local timing pairs, each a bit clock and an 8 kHz frame sync. All timing derives from a single-cycle enable, `ref_en`, that pulses at 32.768 MHz. That is twice the fastest bit clock, so every clock half-period is a whole number of enable ticks. A frame is `FRAME_TICKS` ticks long: 4096 by default, which gives 125 µs. `FRAME_TICKS` must be a power of two and at least 16. One frame counter is shared, so both generators start a new frame on the same tick.

Each generator has its own clock rate, clock polarity, frame-sync polarity and frame-pulse placement. The clock rate is chosen separately from the data rate of the streams that use it. Software writes a 6-bit configuration word through a simple write strobe. That word waits in a pending copy and becomes active on the first tick of the next frame, so a clock or frame pulse is never cut short partway through a frame.

Besides the pin-level clock and sync, the block gives the serial ports three kinds of one-cycle strobes:
- one at the start of each bit period;
- one at the middle of each bit period;
- one at the start of each frame.

Top module: `lclk_fsync_gen`

## Requirements
- R1: After reset the frame counter sits at frame start (tick 0), and both generators hold configuration 0. Both `lclk` outputs are high, both `lfs` outputs are low, and all strobes are low.
- R2: Configuration bits [1:0] select the clock period in ticks: code 0 gives 16 ticks (2.048 MHz), code 1 gives 8, code 2 gives 4 and code 3 gives 2 (16.384 MHz). Without inversion the clock is high for the first half of each period, and periods start at tick 0 of the frame.
- R3: Configuration bit 2 set inverts the clock output.
- R4: Configuration bits [5:4] place the frame pulse; the pulse covers whole ticks of the active configuration:

  | Code | Placement | Ticks covered (P = clock period, H = half period) |
  |------|-----------|---------------------------------------------------|
  | 0 | early | the last P ticks of the frame |
  | 1 | straddle | the last H ticks of one frame and the first H ticks of the next |
  | 2 or 3 | late | the first P ticks of the frame |

- R5: Configuration bit 3 set makes the frame sync active low. Otherwise it is active high.
- R6: A write (`cfg_we` with `cfg_sel` and `cfg_wdata`) changes only the pending copy. The outputs follow the new value from the first tick of the next frame, and never earlier.
- R7: A write with `cfg_sel` = g affects generator g only.
- R8: `bit_stb[g]` pulses for one cycle on the tick where a clock period of generator g begins. `mid_stb[g]` pulses on the tick where its second half begins. The two never pulse together, and neither pulses without a preceding `ref_en`.
- R9: `frm_stb` pulses for one cycle on the tick where the counter returns to 0. Every `bit_stb` bit pulses in that same cycle.
- R10: `lclk` and `lfs` change only in the cycle after a `ref_en` tick, and `lclk[g]` changes whenever `mid_stb[g]` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | Timing tick, 32.768 MHz nominal |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Generator selected by the write |
| cfg_wdata | input | 6 | Configuration word: {format[1:0], fs_inv, clk_inv, rate[1:0]} |
| lclk | output | 2 | Local bit clocks |
| lfs | output | 2 | Local frame syncs |
| bit_stb | output | 2 | Bit-period start strobes |
| mid_stb | output | 2 | Bit-period middle strobes |
| frm_stb | output | 1 | Frame start strobe |

## Verification
Every output is registered on the clock edge that samples `ref_en`. The clock, frame sync and strobes for a tick are therefore due in the cycle right after the enable cycle, and the strobes must be low again one cycle later. The bench raises `ref_en` for exactly one cycle and compares the outputs at the following falling edge against an arithmetic model of the tick count. One cycle later it checks that the strobes have cleared. Configuration writes happen only in cycles without a tick, and the model switches to the pending value at the first tick of the next frame. A write made on the last tick of a frame is therefore due one tick later.

// File: rtl/lclk_fsync_gen.sv
module lclk_fsync_gen #(
  parameter int NGEN        = 2,
  parameter int FRAME_TICKS = 4096
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  ref_en,
  input  logic                                  cfg_we,
  input  logic [(NGEN > 1 ? $clog2(NGEN) : 1)-1:0] cfg_sel,
  input  logic [5:0]                            cfg_wdata,
  output logic [NGEN-1:0]                       lclk,
  output logic [NGEN-1:0]                       lfs,
  output logic [NGEN-1:0]                       bit_stb,
  output logic [NGEN-1:0]                       mid_stb,
  output logic                                  frm_stb
);
  localparam int SELW = NGEN > 1 ? $clog2(NGEN) : 1;
  localparam int CNTW = $clog2(FRAME_TICKS);
  localparam logic [CNTW-1:0] LAST = CNTW'(FRAME_TICKS - 1);

  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] cnt_n;
  logic            wrap;

  assign cnt_n = (cnt == LAST) ? '0 : cnt + CNTW'(1);
  assign wrap  = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      frm_stb <= 1'b0;
    end else begin
      frm_stb <= ref_en & wrap;
      if (ref_en) cnt <= cnt_n;
    end
  end

  for (genvar g = 0; g < NGEN; g++) begin : gen_lt
    logic [5:0]      pend, act, nxt;
    logic [CNTW-1:0] half, per, phase;
    logic            clk_raw, fs_raw;

    assign nxt     = wrap ? pend : act;
    assign half    = CNTW'(8) >> nxt[1:0];
    assign per     = half << 1;
    assign phase   = cnt_n & (per - CNTW'(1));
    assign clk_raw = phase < half;

    always_comb begin
      case (nxt[5:4])
        2'd0:    fs_raw = cnt_n > (LAST - per);
        2'd1:    fs_raw = (cnt_n > (LAST - half)) || (cnt_n < half);
        default: fs_raw = cnt_n < per;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend       <= '0;
        act        <= '0;
        lclk[g]    <= 1'b1;
        lfs[g]     <= 1'b0;
        bit_stb[g] <= 1'b0;
        mid_stb[g] <= 1'b0;
      end else begin
        if (cfg_we && cfg_sel == SELW'(g)) pend <= cfg_wdata;
        bit_stb[g] <= ref_en && phase == '0;
        mid_stb[g] <= ref_en && phase == half;
        if (ref_en) begin
          act     <= nxt;
          lclk[g] <= clk_raw ^ nxt[2];
          lfs[g]  <= fs_raw ^ nxt[3];
        end
      end
    end
  end
endmodule

module lclk_fsync_gen_chk #(
  parameter int NGEN = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ref_en,
  input logic [NGEN-1:0] lclk,
  input logic [NGEN-1:0] lfs,
  input logic [NGEN-1:0] bit_stb,
  input logic [NGEN-1:0] mid_stb,
  input logic            frm_stb
);
  a_r8_strobe_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|bit_stb || |mid_stb || frm_stb) |-> $past(ref_en));

  a_r9_frame_aligns_bits: assert property (@(posedge clk) disable iff (!rst_n)
    frm_stb |-> (&bit_stb));

  a_r10_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ref_en) |-> ($stable(lclk) && $stable(lfs)));

  for (genvar g = 0; g < NGEN; g++) begin : gen_a
    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_stb[g] && mid_stb[g]));

    a_r10_mid_edge: assert property (@(posedge clk) disable iff (!rst_n)
      mid_stb[g] |-> (lclk[g] != $past(lclk[g])));
  end
endmodule

bind lclk_fsync_gen lclk_fsync_gen_chk #(.NGEN(NGEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .lclk(lclk), .lfs(lfs),
  .bit_stb(bit_stb), .mid_stb(mid_stb), .frm_stb(frm_stb)
);

// File: tb/lclk_fsync_gen_bench.sv
module lclk_fsync_gen_bench;
  localparam int F = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [0:0] cfg_sel = '0;
  logic [5:0] cfg_wdata = '0;
  logic [1:0] lclk, lfs, bit_stb, mid_stb;
  logic       frm_stb;

  int checks = 0;
  int fails = 0;
  int bcnt = 0;
  logic [5:0] pend [2];
  logic [5:0] act [2];

  always #2.5 clk = ~clk;

  lclk_fsync_gen #(.NGEN(2), .FRAME_TICKS(F)) u_lclk_fsync_gen (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .lclk(lclk), .lfs(lfs),
    .bit_stb(bit_stb), .mid_stb(mid_stb), .frm_stb(frm_stb)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at tick %0d: actual %0h expected %0h", req, bcnt, got, exp);
    end
  endtask

  function automatic int halfp(input logic [5:0] c);
    return 8 >> c[1:0];
  endfunction

  function automatic logic exp_clk(input int t, input logic [5:0] c);
    return ((t % (2 * halfp(c))) < halfp(c)) ^ c[2];
  endfunction

  function automatic logic exp_fs(input int t, input logic [5:0] c);
    int h = halfp(c);
    logic r;
    case (c[5:4])
      2'd0:    r = t >= F - 2 * h;
      2'd1:    r = (t >= F - h) || (t < h);
      default: r = t < 2 * h;
    endcase
    return r ^ c[3];
  endfunction

  task automatic tick();
    @(negedge clk);
    chk("R8 strobes clear", {bit_stb, mid_stb, frm_stb}, 5'd0);
    ref_en = 1'b1;
    @(negedge clk);
    ref_en = 1'b0;
    bcnt = (bcnt + 1) % F;
    if (bcnt == 0) begin
      act[0] = pend[0];
      act[1] = pend[1];
    end
    for (int g = 0; g < 2; g++) begin
      chk("R2 R3 R6 R7 clock", lclk[g], exp_clk(bcnt, act[g]));
      chk("R4 R5 R6 R7 frame sync", lfs[g], exp_fs(bcnt, act[g]));
      chk("R8 bit strobe", bit_stb[g], (bcnt % (2 * halfp(act[g]))) == 0);
      chk("R8 mid strobe", mid_stb[g], (bcnt % (2 * halfp(act[g]))) == halfp(act[g]));
    end
    chk("R9 frame strobe", frm_stb, bcnt == 0);
  endtask

  task automatic wr(input int g, input logic [5:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = 1'(g);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    pend[g] = d;
  endtask

  task automatic run_to(input int target);
    do tick(); while (bcnt != target);
  endtask

  initial begin
    pend[0] = '0; pend[1] = '0; act[0] = '0; act[1] = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset clocks", lclk, 2'b11);
    chk("R1 reset frame syncs", lfs, 2'b00);
    chk("R1 reset strobes", {bit_stb, mid_stb, frm_stb}, 5'd0);
    run_to(F / 2);
    for (int i = 0; i < 48; i++) begin
      logic [5:0] c0;
      c0 = {2'(i / 16), 1'((i / 8) % 2), 1'((i / 4) % 2), 2'(i % 4)};
      wr(0, c0);
      wr(1, 6'((i * 37 + 11) % 64));
      run_to(0);
      run_to(F / 2);
    end
    // R6 write on the last tick of a frame, due at the next boundary
    run_to(F - 1);
    wr(0, 6'b01_1_0_11);
    wr(1, 6'b11_0_1_00);
    run_to(0);
    run_to(F / 2);
    // R7 only generator 1 reconfigured
    wr(1, 6'b00_1_1_10);
    run_to(0);
    run_to(F / 4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule